// File: doc/BRIEF.md
# Selective Scan Response Compactor

The block folds the serial outputs of several scan chains into a 16-bit multiple-input signature register. After a pattern has been shifted, the tester compares the signature with a stored value. The tester can exclude chains whose captured values are unknown. It does this by shifting one exclude bit per chain into a staging register and then strobing an update, which copies the staging register into an active mask. While a chain's exclude bit is active, that chain feeds 0 into the signature, so its data cannot corrupt the result.

A failing signature only shows that an error happened, not where. For diagnosis, the tester switches the block to bypass mode and replays the pattern. In bypass mode one selected chain is passed straight to the serial output on every shift cycle, and the signature register keeps its value. At the end of a compacted pattern, the signature can be read in parallel, or unloaded serially with the most significant bit first.

Top module: `scan_resp_compactor`

## Requirements
- R1: After reset the signature is 0, every chain is enabled (no exclude bits active), and in compact mode `ser_o` is 0.
- R2: On a compact-mode cycle with `shift_en_i` high, the next signature is `{sig[14:0],0} ^ (sig[15] ? 16'h002D : 0) ^ d`. Here `d` carries the data of chain k in bit k, and 16'h002D is the tap set for x^16+x^5+x^3+x^2+1.
- R3: A chain whose active exclude bit is 1 contributes 0 to `d`, whatever its data.
- R4: `mask_shift_i` shifts `mask_si_i` into the staging register. After N shifts, the first bit shifted in belongs to chain 0. The staging register has no effect until `mask_update_i` copies it into the active mask.
- R5: In bypass mode (`bypass_i`=1), `ser_o` equals the data of chain `chain_sel_i` in the same cycle.
- R6: In bypass mode the signature holds its value while chains shift.
- R7: `sig_clear_i` zeroes the signature on the next edge and takes priority over unload and compaction.
- R8: Each cycle with `unload_i` high, `ser_o` shows the current signature MSB and the signature shifts left with a 0 fill. Sixteen unload cycles therefore emit the signature MSB first.
- R9: Compaction is linear and therefore lossy. An error on chain 0 in cycle t together with an error on chain 1 in cycle t+1 cancels, and the signature is unchanged.
- R10: With `shift_en_i`, `unload_i` and `sig_clear_i` all low, the signature holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chain_i | input | N_CHAINS | Scan chain output bits |
| mask_si_i | input | 1 | Serial exclude-bit data |
| mask_shift_i | input | 1 | Shift staging register |
| mask_update_i | input | 1 | Copy staging register to active mask |
| bypass_i | input | 1 | 1 = bypass, 0 = compact |
| chain_sel_i | input | SEL_W | Chain routed to output in bypass |
| shift_en_i | input | 1 | Scan shift cycle |
| sig_clear_i | input | 1 | Synchronous signature clear |
| unload_i | input | 1 | Serial signature unload |
| sig_o | output | SIG_W | Parallel signature |
| ser_o | output | 1 | Bypass data or signature MSB |

## Verification
The compaction is tried with several exclude patterns: none, a single chain (chain 0, to pin the serial bit order), scattered chains, and all chains. Excluded chains are driven with busy garbage data. The resulting signatures therefore tell a correct mask order and a correct zero-forcing apart from a mask that is reversed or leaks data. A staged but never-updated mask checks that the shadow copy gates the effect. A pair of errors placed one cycle and one bit apart exposes the aliasing property. A run with a single error shows that a lone error does change the signature. Serial unload after each pattern separates MSB-first ordering from LSB-first ordering.

// File: rtl/src_pkg.sv
package src_pkg;
  localparam int unsigned SIG_W    = 16;
  localparam logic [SIG_W-1:0] SIG_TAPS = 16'h002D;
endpackage

// File: rtl/src_mask_ctrl.sv
module src_mask_ctrl #(
  parameter int unsigned N_CHAINS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                si_i,
  input  logic                shift_i,
  input  logic                update_i,
  output logic [N_CHAINS-1:0] mask_o
);
  logic [N_CHAINS-1:0] stage_q, active_q;

  generate
    if (N_CHAINS > 1) begin : g_wide
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni)      stage_q <= '0;
        else if (shift_i) stage_q <= {si_i, stage_q[N_CHAINS-1:1]};
    end else begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni)      stage_q <= '0;
        else if (shift_i) stage_q <= si_i;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)       active_q <= '0;
    else if (update_i) active_q <= stage_q;

  assign mask_o = active_q;

  // R4
  shadow_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !update_i |=> $stable(active_q));
  // R4
  shadow_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_i |=> active_q == $past(stage_q));
endmodule

// File: rtl/src_misr.sv
module src_misr
  import src_pkg::*;
#(
  parameter int unsigned W = SIG_W,
  parameter logic [W-1:0] TAPS = SIG_TAPS
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         unload_i,
  input  logic         comp_en_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] sig_o
);
  logic [W-1:0] q, fb;

  assign fb = q[W-1] ? TAPS : '0;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)        q <= '0;
    else if (clear_i)   q <= '0;
    else if (unload_i)  q <= {q[W-2:0], 1'b0};
    else if (comp_en_i) q <= {q[W-2:0], 1'b0} ^ fb ^ data_i;

  assign sig_o = q;

  // R7
  clear_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> q == '0);
  // R10
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !unload_i && !comp_en_i) |=> $stable(q));
  // R8
  unload_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unload_i && !clear_i) |=> q[0] == 1'b0);
endmodule

// File: rtl/src_out_sel.sv
module src_out_sel #(
  parameter int unsigned N_CHAINS = 8,
  parameter int unsigned SEL_W    = 3,
  parameter int unsigned W        = 16
) (
  input  logic                bypass_i,
  input  logic [N_CHAINS-1:0] chain_i,
  input  logic [SEL_W-1:0]    sel_i,
  input  logic [W-1:0]        sig_i,
  output logic                ser_o
);
  logic byp_bit;

  always_comb begin
    byp_bit = 1'b0;
    for (int k = 0; k < N_CHAINS; k++)
      if (sel_i == SEL_W'(k)) byp_bit = chain_i[k];
  end

  assign ser_o = bypass_i ? byp_bit : sig_i[W-1];
endmodule

// File: rtl/scan_resp_compactor.sv
module scan_resp_compactor
  import src_pkg::*;
#(
  parameter int unsigned N_CHAINS = 8,
  parameter int unsigned SEL_W    = (N_CHAINS > 1) ? $clog2(N_CHAINS) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_CHAINS-1:0] chain_i,
  input  logic                mask_si_i,
  input  logic                mask_shift_i,
  input  logic                mask_update_i,
  input  logic                bypass_i,
  input  logic [SEL_W-1:0]    chain_sel_i,
  input  logic                shift_en_i,
  input  logic                sig_clear_i,
  input  logic                unload_i,
  output logic [SIG_W-1:0]    sig_o,
  output logic                ser_o
);
  localparam int unsigned W = SIG_W;

  logic [N_CHAINS-1:0] mask;
  logic [W-1:0]        comp_d;
  logic                comp_en;

  src_mask_ctrl #(.N_CHAINS(N_CHAINS)) u_mask (
    .clk_i, .rst_ni,
    .si_i(mask_si_i), .shift_i(mask_shift_i), .update_i(mask_update_i),
    .mask_o(mask)
  );

  // Excluded chains feed 0; bits above N_CHAINS are tied off.
  generate
    for (genvar b = 0; b < W; b++) begin : g_din
      if (b < N_CHAINS) begin : g_ch
        assign comp_d[b] = chain_i[b] & ~mask[b];
      end else begin : g_pad
        assign comp_d[b] = 1'b0;
      end
    end
  endgenerate

  assign comp_en = shift_en_i & ~bypass_i;

  src_misr #(.W(W), .TAPS(SIG_TAPS)) u_misr (
    .clk_i, .rst_ni,
    .clear_i(sig_clear_i), .unload_i(unload_i), .comp_en_i(comp_en),
    .data_i(comp_d), .sig_o(sig_o)
  );

  src_out_sel #(.N_CHAINS(N_CHAINS), .SEL_W(SEL_W), .W(W)) u_out (
    .bypass_i, .chain_i, .sel_i(chain_sel_i), .sig_i(sig_o), .ser_o
  );

  // R3
  mask_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (comp_d[N_CHAINS-1:0] & mask) == '0);
  // R6
  bypass_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bypass_i && !sig_clear_i && !unload_i) |=> $stable(sig_o));
endmodule

// File: tb/scan_resp_compactor_bench.sv
module scan_resp_compactor_bench;
  localparam int NC = 8;
  logic clk = 0, rst_n = 0;
  logic [NC-1:0] chain = '0;
  logic msi = 0, mshift = 0, mupd = 0, byp = 0, sen = 0, clr = 0, unl = 0;
  logic [2:0] sel = '0;
  logic [15:0] sig;
  logic ser;
  int n_run = 0, n_fail = 0;
  logic [NC-1:0] mask_cur = '0;
  logic [15:0] model = '0;

  always #2 clk = ~clk;

  scan_resp_compactor u_scan_resp_compactor (
    .clk_i(clk), .rst_ni(rst_n), .chain_i(chain), .mask_si_i(msi),
    .mask_shift_i(mshift), .mask_update_i(mupd), .bypass_i(byp),
    .chain_sel_i(sel), .shift_en_i(sen), .sig_clear_i(clr), .unload_i(unl),
    .sig_o(sig), .ser_o(ser));

  // {mask[7:0], seed[15:0]}
  localparam logic [23:0] VEC [6] = '{
    24'h00_A5C3, 24'h01_1F2E, 24'h24_7B19, 24'h81_C0DE, 24'hFF_3377, 24'h5A_0F0F};

  function automatic logic [15:0] step(input logic [15:0] q, input logic [15:0] d);
    return {q[14:0], 1'b0} ^ (q[15] ? 16'h002D : 16'h0) ^ d;
  endfunction

  function automatic logic [7:0] gen(input logic [15:0] s, input int c);
    logic [15:0] t = s * 16'(c * 7 + 3);
    return t[11:4] ^ s[7:0];
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick; @(posedge clk); #1; endtask

  task automatic load_mask(input logic [7:0] m, input bit upd);
    for (int i = 0; i < NC; i++) begin msi = m[i]; mshift = 1; tick(); end
    mshift = 0; msi = 0;
    if (upd) begin mupd = 1; tick(); mupd = 0; mask_cur = m; end
  endtask

  task automatic compact(input logic [15:0] seed, input int n, input int err);
    clr = 1; tick(); clr = 0; model = '0;
    for (int c = 0; c < n; c++) begin
      logic [7:0] d = gen(seed, c);
      if (err != 0 && c == 2) d ^= 8'h01;
      if (err == 1 && c == 3) d ^= 8'h02;
      chain = d; sen = 1; tick();
      model = step(model, {8'h0, d & ~mask_cur});
    end
    sen = 0; chain = '0;
  endtask

  task automatic unload_check(input string req);
    logic [15:0] got = '0;
    logic [15:0] exp = model;
    unl = 1;
    for (int b = 15; b >= 0; b--) begin got[b] = ser; tick(); end
    unl = 0;
    chk(req, got, exp);
    chk("R8 drained", sig, 16'h0);
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] ref_sig, held;
    #5; rst_n = 1; #2;
    @(negedge clk);
    chk("R1 sig", sig, 16'h0);
    chk("R1 ser", {15'h0, ser}, 16'h0);
    // R1: all chains enabled after reset
    compact(16'h1234, 10, 0);
    chk("R1 R2 no mask", sig, model);

    foreach (VEC[i]) begin
      load_mask(VEC[i][23:16], 1);
      compact(VEC[i][15:0], 12, 0);
      chk("R2 R3 R4 table sig", sig, model);
      unload_check("R8 unload MSB first");
    end

    // R4: staged but not updated mask has no effect
    load_mask(8'h00, 1);
    load_mask(8'hFF, 0);
    compact(16'hBEEF, 10, 0);
    chk("R4 no update", sig, model);
    chk("R4 nonzero", {15'h0, sig != 0}, 16'h1);

    // R9: compensating errors alias
    compact(16'h4242, 10, 0); ref_sig = sig;
    compact(16'h4242, 10, 1);
    chk("R9 alias", sig, ref_sig);
    compact(16'h4242, 10, 2);
    chk("R9 single error seen", {15'h0, sig != ref_sig}, 16'h1);

    // R5 R6 bypass
    compact(16'h9876, 6, 0); held = sig;
    byp = 1; sel = 3'd5;
    for (int c = 0; c < 8; c++) begin
      chain = gen(16'h5555, c); sen = 1; #1;
      chk("R5 bypass ser", {15'h0, ser}, {15'h0, chain[5]});
      tick();
    end
    sen = 0; byp = 0;
    chk("R6 bypass hold", sig, held);

    // R10 idle hold
    for (int c = 0; c < 3; c++) begin chain = gen(16'h0F0F, c); tick(); end
    chk("R10 idle hold", sig, held);

    // R7 clear has priority
    clr = 1; unl = 1; sen = 1; chain = 8'hFF; tick();
    clr = 0; unl = 0; sen = 0; chain = '0;
    chk("R7 clear", sig, 16'h0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule